// File: doc/BRIEF.md
# Multicast Hash Table Filter

This block decides whether a received frame with a group (multicast) destination address should be accepted. It holds a table of one-bit entries, packed into 32-bit registers. It folds the last two bytes of a destination address into a table index with a sliding-window hash. The position of the window depends on the table size and on a two-bit filter type. Software fills the table in three ways: it clears the whole table in one cycle, it overwrites any register through a write port, or it presents an address to a set port, where the block hashes the address and sets the matching bit.

On the receive side the destination address arrives one byte per cycle, with the first byte marked. When the sixth byte arrives, the block hashes bytes 4 and 5 with the current filter type and reads the selected table bit. One cycle later it reports the hash, whether the address was a group address, and whether the frame hits the table. The register count is a power-of-two parameter between 8 and 128. The default of 128 registers gives a 4096-entry table with a 12-bit hash.

Top module: `mcast_hash_filter`

## Requirements
- R1: After the synchronous reset `rst`, every table bit is 0 and `res_valid` is 0, so the first lookup after reset reports no hit.
- R2: With HASH_W = log2(NUM_REGS*32) and base shift B = HASH_W-8, the total shift is S = B plus an offset picked by `filt_type`: 0 gives 0, 1 gives 1, 2 gives 2, 3 gives 4. The hash is the low HASH_W bits of ((byte5 << S) | (byte4 >> (8-S))). For byte4=0x34, byte5=0x56 and 128 registers, the hashes for types 0 to 3 are 0x563, 0xAC6, 0x58D and 0x634.
- R3: A hash selects register hash[HASH_W-1:5] and bit hash[4:0] inside that register. The registered hash is reported on `res_hash`.
- R4: Byte 0 is the byte presented with `rx_valid` and `rx_sof` both high. Later bytes are counted only in cycles where `rx_valid` is high. `res_valid` pulses for exactly one cycle, in the cycle after byte 5 is presented. Bytes after byte 5 produce no result until the next `rx_sof`.
- R5: An address is a group address when bit 0 of byte 0 is 1. For any other address, `res_group` and `res_hit` are 0 while `res_valid` is 1, whatever the table holds.
- R6: A write (`wr_en`) replaces the whole register `wr_idx` with `wr_data`. Bit b of `wr_data` becomes the entry whose bit index is b.
- R7: A set (`set_en`) hashes `set_b4`/`set_b5` with the current `filt_type` and sets that one table bit to 1. All other bits of the register are left unchanged.
- R8: `tbl_clear` zeroes every register. In the same cycle, clear takes priority over write, and write takes priority over set: a set is dropped entirely while `wr_en` or `tbl_clear` is high.
- R9: A lookup reads the table as it was before any write, set or clear presented in the same cycle as byte 5. The update is visible from the next lookup onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_type | input | 2 | Filter type selecting the hash shift offset |
| tbl_clear | input | 1 | Clear every table register |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index for a write |
| wr_data | input | 32 | Register value for a write |
| set_en | input | 1 | Set the bit selected by the hash of set_b4/set_b5 |
| set_b4 | input | 8 | Address byte 4 for a set |
| set_b5 | input | 8 | Address byte 5 for a set |
| rx_valid | input | 1 | Destination address byte valid |
| rx_sof | input | 1 | Marks byte 0 of the destination address |
| rx_byte | input | 8 | Destination address byte |
| res_valid | output | 1 | Lookup result valid (one-cycle pulse) |
| res_group | output | 1 | Address was a group address |
| res_hit | output | 1 | Group address whose table bit is set |
| res_hash | output | HASH_W | Hash of the looked-up address |

## Verification
The hash is exercised on one fixed byte pair under all four filter types, which shows whether each offset is applied. Two more pairs, 0xFF/0x00 and 0x00/0xFF, expose errors in which bits the window keeps at its two ends. Lookups follow register writes that set only the selected bit and writes that set every bit except it, so a misplaced register or bit index shows up as a wrong hit or a wrong miss. Further frames cover unicast first bytes, a set into a register that already holds a bit, updates presented in the cycle of byte 5, same-cycle update conflicts, idle gaps in the middle of an address, and trailing bytes after byte 5. Each of these separates one ordering or priority rule from its neighbours.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int WORD_W  = 32;
    localparam int BIT_W   = 5;
    localparam int BYTE_W  = 8;
    localparam int DA_LAST = 5;

    typedef enum logic [1:0] {
        FT_SHIFT0 = 2'd0,
        FT_SHIFT1 = 2'd1,
        FT_SHIFT2 = 2'd2,
        FT_SHIFT4 = 2'd3
    } filt_type_e;

    typedef struct packed {
        logic valid;
        logic group;
        logic hit;
    } lookup_res_t;

    function automatic logic [3:0] type_offset(filt_type_e t);
        case (t)
            FT_SHIFT1: return 4'd1;
            FT_SHIFT2: return 4'd2;
            FT_SHIFT4: return 4'd4;
            default:   return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/mhf_hash_unit.sv
module mhf_hash_unit
    import mhf_pkg::*;
#(
    parameter  int NUM_REGS = 128,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int HASH_W   = IDX_W + BIT_W
) (
    input  logic [BYTE_W-1:0] b4,
    input  logic [BYTE_W-1:0] b5,
    input  filt_type_e        ftype,
    output logic [HASH_W-1:0] hash,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [BIT_W-1:0]  bit_idx
);
    localparam int BASE_SHIFT = HASH_W - BYTE_W;

    logic [3:0] shamt;

    always_comb begin
        shamt   = 4'(BASE_SHIFT) + type_offset(ftype);
        hash    = (HASH_W'(b5) << shamt) | HASH_W'(b4 >> (4'd8 - shamt));
        reg_idx = hash[HASH_W-1:BIT_W];
        bit_idx = hash[BIT_W-1:0];
    end

endmodule

// File: rtl/mhf_table.sv
module mhf_table
    import mhf_pkg::*;
#(
    parameter  int NUM_REGS = 128,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [BIT_W-1:0]  set_bit,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [BIT_W-1:0]  lk_bit,
    output logic              lk_val
);
    logic [WORD_W-1:0] rows_w [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
        logic [WORD_W-1:0] row_q;
        logic              wr_hit;
        logic              set_hit;

        assign wr_hit  = wr_en && (wr_idx == IDX_W'(r));
        assign set_hit = set_en && !wr_en && (set_idx == IDX_W'(r));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                row_q <= '0;
            end else if (wr_hit) begin
                row_q <= wr_data;
            end else if (set_hit) begin
                row_q[set_bit] <= 1'b1;
            end
        end

        assign rows_w[r] = row_q;
    end

    assign lk_val = rows_w[lk_idx][lk_bit];

endmodule

// File: rtl/mhf_da_tracker.sv
module mhf_da_tracker
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              fire,
    output logic              group,
    output logic [BYTE_W-1:0] byte4
);
    localparam logic [2:0] POS_IDLE = 3'(DA_LAST + 1);

    logic [2:0]        pos_q;
    logic              grp_q;
    logic [BYTE_W-1:0] b4_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_IDLE;
            grp_q <= 1'b0;
            b4_q  <= '0;
        end else if (rx_valid) begin
            if (rx_sof) begin
                pos_q <= 3'd1;
                grp_q <= rx_byte[0];
            end else if (pos_q < POS_IDLE) begin
                pos_q <= pos_q + 3'd1;
                if (pos_q == 3'd4) begin
                    b4_q <= rx_byte;
                end
            end
        end
    end

    assign fire  = rx_valid && !rx_sof && (pos_q == 3'(DA_LAST));
    assign group = grp_q;
    assign byte4 = b4_q;

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
#(
    parameter  int NUM_REGS = 128,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int HASH_W   = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        filt_type,
    input  logic              tbl_clear,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              set_en,
    input  logic [7:0]        set_b4,
    input  logic [7:0]        set_b5,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    output logic              res_valid,
    output logic              res_group,
    output logic              res_hit,
    output logic [HASH_W-1:0] res_hash
);
    filt_type_e ftype;
    assign ftype = filt_type_e'(filt_type);

    logic [HASH_W-1:0] set_hash;
    logic [IDX_W-1:0]  set_idx;
    logic [BIT_W-1:0]  set_bit;

    mhf_hash_unit #(.NUM_REGS(NUM_REGS)) u_set_hash (
        .b4      (set_b4),
        .b5      (set_b5),
        .ftype   (ftype),
        .hash    (set_hash),
        .reg_idx (set_idx),
        .bit_idx (set_bit)
    );

    logic              fire;
    logic              grp;
    logic [BYTE_W-1:0] da_b4;

    mhf_da_tracker u_track (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_byte  (rx_byte),
        .fire     (fire),
        .group    (grp),
        .byte4    (da_b4)
    );

    logic [HASH_W-1:0] lk_hash;
    logic [IDX_W-1:0]  lk_idx;
    logic [BIT_W-1:0]  lk_bit;

    mhf_hash_unit #(.NUM_REGS(NUM_REGS)) u_lk_hash (
        .b4      (da_b4),
        .b5      (rx_byte),
        .ftype   (ftype),
        .hash    (lk_hash),
        .reg_idx (lk_idx),
        .bit_idx (lk_bit)
    );

    logic lk_val;

    mhf_table #(.NUM_REGS(NUM_REGS)) u_table (
        .clk     (clk),
        .rst     (rst),
        .clr     (tbl_clear),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .set_en  (set_en),
        .set_idx (set_idx),
        .set_bit (set_bit),
        .lk_idx  (lk_idx),
        .lk_bit  (lk_bit),
        .lk_val  (lk_val)
    );

    lookup_res_t       res_q;
    logic [HASH_W-1:0] hash_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            hash_q <= '0;
        end else begin
            res_q.valid <= fire;
            res_q.group <= fire && grp;
            res_q.hit   <= fire && grp && lk_val;
            if (fire) begin
                hash_q <= lk_hash;
            end
        end
    end

    assign res_valid = res_q.valid;
    assign res_group = res_q.group;
    assign res_hit   = res_q.hit;
    assign res_hash  = hash_q;

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter  int NUM_REGS = 128,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int HASH_W   = IDX_W + 5
) (
    input logic              clk,
    input logic              rst,
    input logic              tbl_clear,
    input logic              rx_valid,
    input logic              rx_sof,
    input logic              res_valid,
    input logic              res_group,
    input logic              res_hit,
    input logic [HASH_W-1:0] res_hash
);
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !res_valid); // R1

    AST_RESULT_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(rx_valid) && !$past(rx_sof))); // R4

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_valid); // R4

    AST_UNICAST_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_group) |-> !res_hit); // R5

    AST_GROUP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        res_group |-> res_valid); // R5

    AST_CLEAR_EMPTIES_TABLE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(tbl_clear, 2)) |-> !res_hit); // R8

    AST_HASH_STEADY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!res_valid && !$past(rst)) |-> $stable(res_hash)); // R3

endmodule

bind mcast_hash_filter mhf_checker #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/mcast_hash_filter_tb_top.sv
module mcast_hash_filter_tb_top;

    localparam int NUM_REGS = 128;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int HASH_W   = IDX_W + 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        filt_type = 2'd0;
    logic              tbl_clear = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [31:0]       wr_data = '0;
    logic              set_en = 1'b0;
    logic [7:0]        set_b4 = '0;
    logic [7:0]        set_b5 = '0;
    logic              rx_valid = 1'b0;
    logic              rx_sof = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic              res_valid;
    logic              res_group;
    logic              res_hit;
    logic [HASH_W-1:0] res_hash;

    always #5 clk = ~clk;

    mcast_hash_filter #(.NUM_REGS(NUM_REGS)) dut_i (.*);

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] shadow [NUM_REGS];

    logic        got_valid, got_group, got_hit, got_valid_next;
    logic [31:0] got_hash;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_hash(input int b4, input int b5, input int t);
        int s;
        s = (HASH_W - 8) + ((t == 3) ? 4 : t);
        return ((b5 * (1 << s)) + (b4 / (1 << (8 - s)))) % (1 << HASH_W);
    endfunction

    function automatic bit model_hit(input logic [7:0] b0, input int h);
        return b0[0] && shadow[h / 32][h % 32];
    endfunction

    task automatic shadow_clear();
        for (int i = 0; i < NUM_REGS; i++) shadow[i] = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        shadow_clear();
        @(negedge clk);
    endtask

    task automatic tbl_write(input int idx, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[idx] = d;
    endtask

    task automatic tbl_set(input logic [7:0] b4, input logic [7:0] b5);
        int h;
        set_en = 1'b1; set_b4 = b4; set_b5 = b5;
        @(negedge clk);
        set_en = 1'b0;
        h = model_hash(b4, b5, filt_type);
        shadow[h / 32][h % 32] = 1'b1;
    endtask

    task automatic tbl_clr();
        tbl_clear = 1'b1;
        @(negedge clk);
        tbl_clear = 1'b0;
        shadow_clear();
    endtask

    // Sends a six-byte destination address; optional idle gap after byte 2,
    // optional register write presented in the cycle of byte 5.
    task automatic send_frame(input logic [7:0] b0, input logic [7:0] b4, input logic [7:0] b5,
                              input int gap, input bit wr_b5, input int wi, input logic [31:0] wd);
        logic [7:0] seq [6];
        seq[0] = b0; seq[1] = 8'h11; seq[2] = 8'h22; seq[3] = 8'h33; seq[4] = b4; seq[5] = b5;
        for (int k = 0; k < 6; k++) begin
            rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = seq[k];
            if (k == 5 && wr_b5) begin
                wr_en = 1'b1; wr_idx = IDX_W'(wi); wr_data = wd;
            end
            @(negedge clk);
            if (k == 2) begin
                for (int g = 0; g < gap; g++) begin
                    rx_valid = 1'b0; rx_sof = 1'b0;
                    @(negedge clk);
                    chk(res_valid == 1'b0, "R4", "valid during gap", res_valid, 0);
                end
            end
        end
        got_valid = res_valid; got_group = res_group; got_hit = res_hit;
        got_hash  = 32'(res_hash);
        rx_valid = 1'b0; rx_sof = 1'b0; wr_en = 1'b0;
        if (wr_b5) shadow[wi] = wd;
        @(negedge clk);
        got_valid_next = res_valid;
    endtask

    task automatic lookup(input string req, input logic [7:0] b0, input logic [7:0] b4,
                          input logic [7:0] b5);
        int h;
        h = model_hash(b4, b5, filt_type);
        send_frame(b0, b4, b5, 0, 1'b0, 0, 0);
        chk(got_valid == 1'b1, req, "res_valid", got_valid, 1);
        chk(got_valid_next == 1'b0, "R4", "res_valid pulse", got_valid_next, 0);
        chk(got_group == b0[0], req, "res_group", got_group, b0[0]);
        chk(got_hit == model_hit(b0, h), req, "res_hit", got_hit, model_hit(b0, h));
        chk(got_hash == 32'(h), req, "res_hash", got_hash, h);
    endtask

    task automatic t_reset();
        chk(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        filt_type = 2'd0;
        lookup("R1", 8'h01, 8'h34, 8'h56);
        chk(got_hit == 1'b0, "R1", "hit on empty table", got_hit, 0);
    endtask

    task automatic t_hash_types();
        logic [31:0] exp_h [4];
        exp_h[0] = 32'h563; exp_h[1] = 32'hAC6; exp_h[2] = 32'h58D; exp_h[3] = 32'h634;
        for (int t = 0; t < 4; t++) begin
            filt_type = 2'(t);
            lookup("R2", 8'h01, 8'h34, 8'h56);
            chk(got_hash == exp_h[t], "R2", "fixed hash per type", got_hash, exp_h[t]);
        end
        filt_type = 2'd0;
        lookup("R2", 8'h01, 8'hFF, 8'h00);
        chk(got_hash == 32'h00F, "R2", "byte4 window edge", got_hash, 32'h00F);
        filt_type = 2'd3;
        lookup("R2", 8'h01, 8'h00, 8'hFF);
        chk(got_hash == 32'hF00, "R2", "byte5 window edge", got_hash, 32'hF00);
    endtask

    task automatic t_write_index();
        filt_type = 2'd0;                      // hash 0x563 -> reg 0x2B bit 3
        tbl_write(32'h2B, 32'h0000_0008);
        lookup("R3", 8'h01, 8'h34, 8'h56);
        chk(got_hit == 1'b1, "R6", "single bit written", got_hit, 1);
        tbl_write(32'h2B, 32'hFFFF_FFF7);
        lookup("R6", 8'h01, 8'h34, 8'h56);
        chk(got_hit == 1'b0, "R3", "all but selected bit", got_hit, 0);
        filt_type = 2'd3;                      // hash 0xF00 -> reg 0x78 bit 0
        tbl_write(32'h78, 32'h0000_0001);
        lookup("R3", 8'h01, 8'h00, 8'hFF);
        chk(got_hit == 1'b1, "R3", "reg 0x78 bit 0", got_hit, 1);
    endtask

    task automatic t_set_port();
        tbl_clr();
        filt_type = 2'd1;                      // 0x34/0x56 -> 0xAC6 -> reg 0x56 bit 6
        tbl_write(32'h56, 32'h0000_0001);
        tbl_set(8'h34, 8'h56);
        lookup("R7", 8'h01, 8'h34, 8'h56);
        chk(got_hit == 1'b1, "R7", "set bit hits", got_hit, 1);
        lookup("R7", 8'h01, 8'h00, 8'h56);     // 0xAC0 -> reg 0x56 bit 0
        chk(got_hit == 1'b1, "R7", "other bit kept", got_hit, 1);
    endtask

    task automatic t_unicast();
        filt_type = 2'd1;
        lookup("R5", 8'h00, 8'h34, 8'h56);
        chk(got_hit == 1'b0, "R5", "unicast with bit set", got_hit, 0);
        lookup("R5", 8'h02, 8'h34, 8'h56);
        chk(got_group == 1'b0, "R5", "bit1-only first byte", got_group, 0);
    endtask

    task automatic t_clear_priority();
        filt_type = 2'd1;
        tbl_clr();
        lookup("R8", 8'h01, 8'h34, 8'h56);
        chk(got_hit == 1'b0, "R8", "clear removes bit", got_hit, 0);
        tbl_clear = 1'b1; wr_en = 1'b1; wr_idx = IDX_W'(32'h56); wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        tbl_clear = 1'b0; wr_en = 1'b0; shadow_clear();
        lookup("R8", 8'h01, 8'h34, 8'h56);
        chk(got_hit == 1'b0, "R8", "clear beats write", got_hit, 0);
        wr_en = 1'b1; wr_idx = IDX_W'(32'h10); wr_data = 32'h1;
        set_en = 1'b1; set_b4 = 8'h34; set_b5 = 8'h56;
        @(negedge clk);
        wr_en = 1'b0; set_en = 1'b0; shadow[32'h10] = 32'h1;
        lookup("R8", 8'h01, 8'h34, 8'h56);
        chk(got_hit == 1'b0, "R8", "set dropped under write", got_hit, 0);
    endtask

    task automatic t_same_cycle();
        filt_type = 2'd0;
        tbl_clr();
        send_frame(8'h01, 8'h34, 8'h56, 0, 1'b1, 32'h2B, 32'h8);
        chk(got_hit == 1'b0, "R9", "old table at byte 5", got_hit, 0);
        lookup("R9", 8'h01, 8'h34, 8'h56);
        chk(got_hit == 1'b1, "R9", "update seen next frame", got_hit, 1);
    endtask

    task automatic t_stall();
        filt_type = 2'd0;
        send_frame(8'h01, 8'h34, 8'h56, 3, 1'b0, 0, 0);
        chk(got_valid == 1'b1, "R4", "valid after gaps", got_valid, 1);
        chk(got_hit == 1'b1, "R4", "hit after gaps", got_hit, 1);
        chk(got_hash == 32'h563, "R4", "hash after gaps", got_hash, 32'h563);
        rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'h56;
        repeat (3) @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        chk(res_valid == 1'b0, "R4", "trailing bytes ignored", res_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_hash_types();
        t_write_index();
        t_set_port();
        t_unicast();
        t_clear_priority();
        t_same_cycle();
        t_stall();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule